// File: doc/BRIEF.md
# Programmable Chip Select Generator

This block decodes accesses on an ISA-style expansion bus and drives active-low chip selects for up to two external devices. Each channel has a base address and an address mask. It also has a small configuration field that sets three things. The first is whether the channel responds to memory cycles or to I/O cycles. The second is whether the device is 16 bits wide. The third is which bus strobe, if any, must accompany the address match before the select is driven.

Software programs the channels through a plain synchronous register port with a write enable, a register select and a data word. Read data is returned combinationally for the register currently selected. The chip selects and the 16-bit cycle request are purely combinational from the bus inputs and the stored configuration. They follow the bus within the same clock period.

The configuration is cleared only by the real-time-clock reset input, which is asynchronous and active high. No other reset exists at this block, so the programmed state survives any system-level reset that does not assert that input.

Top module: `pcs_gen`

## Requirements
- R1: A channel whose mode field is 00 keeps its chip select high, and it adds nothing to the 16-bit request, whatever the bus inputs are.
- R2: With mode 01, a channel drives its select low only while the address matches, the cycle type is right and `bus_rd_n_i` is low.
- R3: With mode 10, a channel drives its select low only while the address matches, the cycle type is right and `bus_wr_n_i` is low.
- R4: With mode 11, a channel drives its select low on address match and correct cycle type alone, with both strobes high.
- R5: The target-cycle bit selects the cycle type. When it is 0 the channel may assert only while `bus_mem_i` is 0 (I/O cycle). When it is 1 the channel may assert only while `bus_mem_i` is 1 (memory cycle).
- R6: The address matches when `bus_addr_i` equals the channel base on every bit set in the channel mask. Bits cleared in the mask are ignored, so a zero mask matches every address.
- R7: A channel that is enabled, has the right cycle type and matches the address asks for a 16-bit cycle (`req16_o` high) in two cases: its size bit is 1, or either `mem16_n_i` or `io16_n_i` is low. A channel that does not match asks for nothing.
- R8: Register select 0 is the control word. Channel c's fields sit in bits 4c+3..4c, with bit 4c+3 the target-cycle bit, bit 4c+2 the size bit and bits 4c+1..4c the mode. Select 1+2c is channel c's base and select 2+2c is its mask. A write takes effect at the clock edge on which `reg_we_i` is sampled high, and not before.
- R9: Control bits above the implemented channel fields (bits 15:8 for two channels) read as zero and ignore writes. Select values with no register read zero and writes to them change nothing.
- R10: A high level on `rtc_rst_i` clears the control word, all bases and all masks to zero at once, without waiting for a clock. All chip selects then read high.
- R11: When both channels match the same access, both chip selects assert together, and `req16_o` is the OR of the two channels' size decisions.
- R12: Chip selects respond to a change of the bus address within the same clock period, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register port clock |
| rtc_rst_i | input | 1 | Real-time-clock reset, asynchronous, active high |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | SEL_W (3) | Register select: 0 control, 1+2c base, 2+2c mask |
| reg_wdata_i | input | ADDR_W (24) | Register write data |
| reg_rdata_o | output | ADDR_W (24) | Read data of the selected register |
| bus_addr_i | input | ADDR_W (24) | Bus address |
| bus_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_rd_n_i | input | 1 | Read strobe, active low |
| bus_wr_n_i | input | 1 | Write strobe, active low |
| mem16_n_i | input | 1 | Memory device 16-bit acknowledge, active low |
| io16_n_i | input | 1 | I/O device 16-bit acknowledge, active low |
| cs_n_o | output | NUM_CH (2) | Chip selects, active low, one per channel |
| req16_o | output | 1 | Request for a 16-bit bus cycle |

## Verification
The bench builds the block with its default values, two channels and a 24-bit address. With two channels, the field layout of the upper channel can be checked, and so can the case where both channels decode one access. The 24-bit address lets the mask tests compare bits above bit 15 and treat the top nibble alone as a page decode. Since the bench uses the default configuration width, the reserved control bits 15:8 can be written with ones and read back as zero.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Width of the software-visible control word and of one channel field.
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned FIELD_W = 4;

  // How a channel's select is qualified once its address decodes.
  typedef enum logic [1:0] {
    QUAL_OFF  = 2'b00,
    QUAL_RD   = 2'b01,
    QUAL_WR   = 2'b10,
    QUAL_ADDR = 2'b11
  } qual_e;

  // One channel's field, most significant member first.
  typedef struct packed {
    logic  mem_space;  // 1: memory cycles, 0: I/O cycles
    logic  wide;       // 1: device is always 16 bits
    qual_e qual;
  } chan_cfg_t;

endpackage

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs
  import pcs_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                           clk_i,
  input  logic                           rtc_rst_i,
  input  logic                           we_i,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [ADDR_W-1:0]              wdata_i,
  output logic [ADDR_W-1:0]              rdata_o,
  output chan_cfg_t [NUM_CH-1:0]         cfg_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  base_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  mask_o
);

  localparam int unsigned CFG_BITS = NUM_CH * FIELD_W;
  localparam logic [SEL_W-1:0] CTRL_SEL = '0;

  // Only the implemented field bits are stored; reserved bits have no flop.
  logic [CFG_BITS-1:0] ctrl_q;

  always_ff @(posedge clk_i or posedge rtc_rst_i) begin
    if (rtc_rst_i) begin
      ctrl_q <= '0;
    end else if (we_i && (sel_i == CTRL_SEL)) begin
      ctrl_q <= wdata_i[CFG_BITS-1:0];
    end
  end

  assign cfg_o = ctrl_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_win
    localparam logic [SEL_W-1:0] BASE_SEL = SEL_W'(1 + 2 * ch);
    localparam logic [SEL_W-1:0] MASK_SEL = SEL_W'(2 + 2 * ch);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] mask_q;

    always_ff @(posedge clk_i or posedge rtc_rst_i) begin
      if (rtc_rst_i) begin
        base_q <= '0;
        mask_q <= '0;
      end else if (we_i) begin
        if (sel_i == BASE_SEL) base_q <= wdata_i;
        if (sel_i == MASK_SEL) mask_q <= wdata_i;
      end
    end

    assign base_o[ch] = base_q;
    assign mask_o[ch] = mask_q;
  end

  // Read mux: unassigned selects and reserved bits return zero.
  always_comb begin
    rdata_o = '0;
    if (sel_i == CTRL_SEL) begin
      rdata_o[CFG_BITS-1:0] = ctrl_q;
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (sel_i == SEL_W'(1 + 2 * ch)) rdata_o = base_o[ch];
      if (sel_i == SEL_W'(2 + 2 * ch)) rdata_o = mask_o[ch];
    end
  end

endmodule

// File: rtl/pcs_chan_decode.sv
module pcs_chan_decode
  import pcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  chan_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  mask_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               mem_cyc_i,
  input  logic               rd_n_i,
  input  logic               wr_n_i,
  input  logic               ack16_i,
  output logic               cs_n_o,
  output logic               wide_o
);

  logic addr_hit;
  logic space_ok;
  logic enabled;
  logic decoded;
  logic strobe_ok;

  assign addr_hit = (((addr_i ^ base_i) & mask_i) == '0);
  assign space_ok = (cfg_i.mem_space == mem_cyc_i);
  assign enabled  = (cfg_i.qual != QUAL_OFF);
  assign decoded  = enabled && space_ok && addr_hit;

  always_comb begin
    unique case (cfg_i.qual)
      QUAL_RD:   strobe_ok = !rd_n_i;
      QUAL_WR:   strobe_ok = !wr_n_i;
      QUAL_ADDR: strobe_ok = 1'b1;
      default:   strobe_ok = 1'b0;
    endcase
  end

  // The size decision follows the decode alone; the strobe gates only the select.
  assign cs_n_o = !(decoded && strobe_ok);
  assign wide_o = decoded && (cfg_i.wide || ack16_i);

endmodule

// File: rtl/pcs_gen.sv
module pcs_gen
  import pcs_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SEL_W  = $clog2(2 * NUM_CH + 1)
) (
  input  logic               clk_i,
  input  logic               rtc_rst_i,
  input  logic               reg_we_i,
  input  logic [SEL_W-1:0]   reg_sel_i,
  input  logic [ADDR_W-1:0]  reg_wdata_i,
  output logic [ADDR_W-1:0]  reg_rdata_o,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_mem_i,
  input  logic               bus_rd_n_i,
  input  logic               bus_wr_n_i,
  input  logic               mem16_n_i,
  input  logic               io16_n_i,
  output logic [NUM_CH-1:0]  cs_n_o,
  output logic               req16_o
);

  chan_cfg_t [NUM_CH-1:0]         cfg_w;
  logic [NUM_CH-1:0][ADDR_W-1:0]  base_w;
  logic [NUM_CH-1:0][ADDR_W-1:0]  mask_w;
  logic [NUM_CH-1:0]              wide_w;
  logic                           ack16_w;

  pcs_cfg_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rtc_rst_i (rtc_rst_i),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .cfg_o     (cfg_w),
    .base_o    (base_w),
    .mask_o    (mask_w)
  );

  // Either device acknowledge widens an 8-bit channel.
  assign ack16_w = !mem16_n_i || !io16_n_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pcs_chan_decode #(
      .ADDR_W (ADDR_W)
    ) u_dec (
      .cfg_i     (cfg_w[ch]),
      .base_i    (base_w[ch]),
      .mask_i    (mask_w[ch]),
      .addr_i    (bus_addr_i),
      .mem_cyc_i (bus_mem_i),
      .rd_n_i    (bus_rd_n_i),
      .wr_n_i    (bus_wr_n_i),
      .ack16_i   (ack16_w),
      .cs_n_o    (cs_n_o[ch]),
      .wide_o    (wide_w[ch])
    );
  end

  assign req16_o = |wide_w;

endmodule

// File: rtl/pcs_gen_chk.sv
module pcs_gen_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SEL_W  = 3
) (
  input logic                          clk_i,
  input logic                          rtc_rst_i,
  input logic                          reg_we_i,
  input logic [SEL_W-1:0]              reg_sel_i,
  input logic [ADDR_W-1:0]             reg_wdata_i,
  input logic [ADDR_W-1:0]             reg_rdata_i,
  input logic [NUM_CH*4-1:0]           cfg_bits_i,
  input logic [NUM_CH-1:0][ADDR_W-1:0] base_i,
  input logic [NUM_CH-1:0][ADDR_W-1:0] mask_i,
  input logic [ADDR_W-1:0]             bus_addr_i,
  input logic                          bus_mem_i,
  input logic                          bus_rd_n_i,
  input logic                          bus_wr_n_i,
  input logic [NUM_CH-1:0]             cs_n_i,
  input logic                          req16_i
);

  localparam int unsigned CFG_BITS = NUM_CH * 4;

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (rtc_rst_i)
    (reg_we_i && reg_sel_i == '0) |=> (cfg_bits_i == $past(reg_wdata_i[CFG_BITS-1:0]))); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (rtc_rst_i)
    (reg_sel_i == '0) |-> (reg_rdata_i[ADDR_W-1:CFG_BITS] == '0)); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (rtc_rst_i)
      (cfg_bits_i[4*c +: 2] == 2'b00) |-> cs_n_i[c]); // R1

    AST_RD_GATED: assert property (@(posedge clk_i) disable iff (rtc_rst_i)
      (!cs_n_i[c] && cfg_bits_i[4*c +: 2] == 2'b01) |-> !bus_rd_n_i); // R2

    AST_WR_GATED: assert property (@(posedge clk_i) disable iff (rtc_rst_i)
      (!cs_n_i[c] && cfg_bits_i[4*c +: 2] == 2'b10) |-> !bus_wr_n_i); // R3

    AST_SPACE_OK: assert property (@(posedge clk_i) disable iff (rtc_rst_i)
      !cs_n_i[c] |-> (bus_mem_i == cfg_bits_i[4*c+3])); // R5

    AST_ADDR_HIT: assert property (@(posedge clk_i) disable iff (rtc_rst_i)
      !cs_n_i[c] |-> (((bus_addr_i ^ base_i[c]) & mask_i[c]) == '0)); // R6

    AST_WIDE_REQ: assert property (@(posedge clk_i) disable iff (rtc_rst_i)
      (!cs_n_i[c] && cfg_bits_i[4*c+2]) |-> req16_i); // R7
  end

endmodule

bind pcs_gen pcs_gen_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rtc_rst_i   (rtc_rst_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_i (reg_rdata_o),
  .cfg_bits_i  (cfg_w),
  .base_i      (base_w),
  .mask_i      (mask_w),
  .bus_addr_i  (bus_addr_i),
  .bus_mem_i   (bus_mem_i),
  .bus_rd_n_i  (bus_rd_n_i),
  .bus_wr_n_i  (bus_wr_n_i),
  .cs_n_i      (cs_n_o),
  .req16_i     (req16_o)
);

// File: tb/sim_pcs_gen.sv
module sim_pcs_gen;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned SEL_W  = 3;

  logic              clk = 1'b0;
  logic              rtc_rst;
  logic              reg_we;
  logic [SEL_W-1:0]  reg_sel;
  logic [ADDR_W-1:0] reg_wdata;
  logic [ADDR_W-1:0] reg_rdata;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_mem;
  logic              bus_rd_n;
  logic              bus_wr_n;
  logic              mem16_n;
  logic              io16_n;
  logic [NUM_CH-1:0] cs_n;
  logic              req16;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  pcs_gen #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W)
  ) u0 (
    .clk_i       (clk),
    .rtc_rst_i   (rtc_rst),
    .reg_we_i    (reg_we),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .bus_addr_i  (bus_addr),
    .bus_mem_i   (bus_mem),
    .bus_rd_n_i  (bus_rd_n),
    .bus_wr_n_i  (bus_wr_n),
    .mem16_n_i   (mem16_n),
    .io16_n_i    (io16_n),
    .cs_n_o      (cs_n),
    .req16_o     (req16)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [SEL_W-1:0] sel, input logic [ADDR_W-1:0] data);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_sel   = sel;
    reg_wdata = data;
    @(negedge clk);
    reg_we    = 1'b0;
    reg_sel   = '0;
  endtask

  task automatic read_reg(input logic [SEL_W-1:0] sel, output logic [ADDR_W-1:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  task automatic set_bus(input logic [ADDR_W-1:0] addr, input logic mem,
                         input logic rd_n, input logic wr_n,
                         input logic m16_n, input logic i16_n);
    @(negedge clk);
    bus_addr = addr;
    bus_mem  = mem;
    bus_rd_n = rd_n;
    bus_wr_n = wr_n;
    mem16_n  = m16_n;
    io16_n   = i16_n;
    #1;
  endtask

  task automatic setup_ch(input int ch, input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] mask);
    write_reg(SEL_W'(1 + 2 * ch), base);
    write_reg(SEL_W'(2 + 2 * ch), mask);
  endtask

  task automatic test_reset();
    logic [ADDR_W-1:0] rd;
    check("R10", "cs_n after reset", 32'(cs_n), 32'h3);
    check("R10", "req16 after reset", 32'(req16), 32'h0);
    read_reg(3'd0, rd);
    check("R10", "ctrl after reset", 32'(rd), 32'h0);
    read_reg(3'd1, rd);
    check("R10", "base0 after reset", 32'(rd), 32'h0);
    read_reg(3'd4, rd);
    check("R10", "mask1 after reset", 32'(rd), 32'h0);
  endtask

  task automatic test_reg_rw();
    logic [ADDR_W-1:0] rd;
    write_reg(3'd0, 24'h00FFFF);
    read_reg(3'd0, rd);
    check("R9", "reserved ctrl bits", 32'(rd), 32'h0000FF);
    write_reg(3'd0, 24'h00AB5A);
    read_reg(3'd0, rd);
    check("R9", "ctrl low byte only", 32'(rd), 32'h00005A);
    write_reg(3'd1, 24'hABCDEF);
    read_reg(3'd1, rd);
    check("R8", "base0 readback", 32'(rd), 32'hABCDEF);
    write_reg(3'd4, 24'h00F0F0);
    read_reg(3'd4, rd);
    check("R8", "mask1 readback", 32'(rd), 32'h00F0F0);
    write_reg(3'd7, 24'hFFFFFF);
    read_reg(3'd7, rd);
    check("R9", "unmapped select reads zero", 32'(rd), 32'h0);
    read_reg(3'd1, rd);
    check("R9", "unmapped write leaves base0", 32'(rd), 32'hABCDEF);
    read_reg(3'd0, rd);
    check("R9", "unmapped write leaves ctrl", 32'(rd), 32'h00005A);
    write_reg(3'd0, 24'h0);
  endtask

  task automatic test_layout();
    setup_ch(0, 24'h000200, 24'hFFFF00);
    setup_ch(1, 24'h000200, 24'hFFFF00);
    set_bus(24'h000210, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R8", "no select before write", 32'(cs_n), 32'h3);
    // Channel 1 field in bits 7:4: I/O space, 8-bit, address-only mode.
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 24'h000030;
    #1;
    check("R8", "write not yet effective", 32'(cs_n), 32'h3);
    @(posedge clk);
    #1;
    check("R8", "channel 1 field active", 32'(cs_n), 32'h1);
    @(negedge clk);
    reg_we = 1'b0;
    write_reg(3'd0, 24'h000003);
    #1;
    check("R8", "channel 0 field active", 32'(cs_n), 32'h2);
    write_reg(3'd0, 24'h0);
  endtask

  task automatic test_disabled();
    setup_ch(0, 24'h000300, 24'hFFFFF0);
    set_bus(24'h000300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1", "mode 00 select", 32'(cs_n), 32'h3);
    check("R1", "mode 00 req16", 32'(req16), 32'h0);
    write_reg(3'd0, 24'h00000C);  // memory, wide, still mode 00
    set_bus(24'h000300, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1", "mode 00 wide select", 32'(cs_n), 32'h3);
    check("R1", "mode 00 wide req16", 32'(req16), 32'h0);
  endtask

  task automatic test_read_qual();
    write_reg(3'd0, 24'h000001);
    set_bus(24'h000305, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R2", "no strobe", 32'(cs_n), 32'h3);
    set_bus(24'h000305, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R2", "read strobe", 32'(cs_n), 32'h2);
    set_bus(24'h000305, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R2", "write strobe ignored", 32'(cs_n), 32'h3);
    set_bus(24'h000405, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R2", "read strobe, miss", 32'(cs_n), 32'h3);
  endtask

  task automatic test_write_qual();
    write_reg(3'd0, 24'h000002);
    set_bus(24'h000305, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R3", "write strobe", 32'(cs_n), 32'h2);
    set_bus(24'h000305, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R3", "read strobe ignored", 32'(cs_n), 32'h3);
  endtask

  task automatic test_addr_only();
    write_reg(3'd0, 24'h000003);
    set_bus(24'h00030A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R4", "address alone", 32'(cs_n), 32'h2);
    // Within one half period: no clock edge in between.
    bus_addr = 24'h00040A;
    #1;
    check("R12", "follows miss without clock", 32'(cs_n), 32'h3);
    bus_addr = 24'h00030A;
    #1;
    check("R12", "follows hit without clock", 32'(cs_n), 32'h2);
  endtask

  task automatic test_cycle_type();
    write_reg(3'd0, 24'h000003);
    set_bus(24'h000300, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R5", "I/O channel on memory cycle", 32'(cs_n), 32'h3);
    set_bus(24'h000300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R5", "I/O channel on I/O cycle", 32'(cs_n), 32'h2);
    write_reg(3'd0, 24'h00000B);
    set_bus(24'h000300, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R5", "memory channel on memory cycle", 32'(cs_n), 32'h2);
    set_bus(24'h000300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R5", "memory channel on I/O cycle", 32'(cs_n), 32'h3);
  endtask

  task automatic test_mask();
    write_reg(3'd0, 24'h000003);
    setup_ch(0, 24'h000300, 24'hFFFFF0);
    set_bus(24'h00030F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R6", "masked low bits", 32'(cs_n), 32'h2);
    set_bus(24'h000310, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R6", "bit 4 differs", 32'(cs_n), 32'h3);
    set_bus(24'h100300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R6", "bit 20 differs", 32'(cs_n), 32'h3);
    setup_ch(0, 24'h000300, 24'h000000);
    set_bus(24'hFFFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R6", "zero mask matches all", 32'(cs_n), 32'h2);
    setup_ch(0, 24'h500000, 24'hF00000);
    set_bus(24'h5ABCDE, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R6", "page hit", 32'(cs_n), 32'h2);
    set_bus(24'h4ABCDE, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R6", "page miss", 32'(cs_n), 32'h3);
  endtask

  task automatic test_size();
    setup_ch(0, 24'h000300, 24'hFFFFF0);
    write_reg(3'd0, 24'h000003);
    set_bus(24'h000300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R7", "8-bit, no ack", 32'(req16), 32'h0);
    set_bus(24'h000300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R7", "8-bit, io16 ack", 32'(req16), 32'h1);
    set_bus(24'h000300, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R7", "8-bit, mem16 ack", 32'(req16), 32'h1);
    write_reg(3'd0, 24'h000007);
    set_bus(24'h000300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R7", "16-bit device", 32'(req16), 32'h1);
    set_bus(24'h000400, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R7", "16-bit device, miss", 32'(req16), 32'h0);
    set_bus(24'h000400, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R7", "miss with ack", 32'(req16), 32'h0);
  endtask

  task automatic test_both();
    setup_ch(0, 24'h000300, 24'hFFFFF0);
    setup_ch(1, 24'h000300, 24'hFFFFF0);
    write_reg(3'd0, 24'h000073);  // ch1 wide address-only, ch0 8-bit address-only
    set_bus(24'h000300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R11", "both selects", 32'(cs_n), 32'h0);
    check("R11", "req16 from channel 1", 32'(req16), 32'h1);
    setup_ch(1, 24'h000400, 24'hFFFFF0);
    set_bus(24'h000300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R11", "only channel 0", 32'(cs_n), 32'h2);
    check("R11", "8-bit channel alone", 32'(req16), 32'h0);
    set_bus(24'h000400, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R11", "only channel 1", 32'(cs_n), 32'h1);
    check("R11", "wide channel alone", 32'(req16), 32'h1);
  endtask

  task automatic test_rtc_reset();
    logic [ADDR_W-1:0] rd;
    setup_ch(0, 24'h000300, 24'hFFFFF0);
    write_reg(3'd0, 24'h000003);
    set_bus(24'h000300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R10", "select before reset", 32'(cs_n), 32'h2);
    @(negedge clk);
    #1;
    rtc_rst = 1'b1;
    #1;
    check("R10", "select cleared without clock", 32'(cs_n), 32'h3);
    rtc_rst = 1'b0;
    #1;
    read_reg(3'd0, rd);
    check("R10", "ctrl cleared", 32'(rd), 32'h0);
    read_reg(3'd1, rd);
    check("R10", "base0 cleared", 32'(rd), 32'h0);
    read_reg(3'd2, rd);
    check("R10", "mask0 cleared", 32'(rd), 32'h0);
  endtask

  initial begin
    rtc_rst   = 1'b1;
    reg_we    = 1'b0;
    reg_sel   = '0;
    reg_wdata = '0;
    bus_addr  = '0;
    bus_mem   = 1'b0;
    bus_rd_n  = 1'b1;
    bus_wr_n  = 1'b1;
    mem16_n   = 1'b1;
    io16_n    = 1'b1;
    #22;
    rtc_rst = 1'b0;
    #1;
    test_reset();
    test_reg_rw();
    test_layout();
    test_disabled();
    test_read_qual();
    test_write_qual();
    test_addr_only();
    test_cycle_type();
    test_mask();
    test_size();
    test_both();
    test_rtc_reset();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #500000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule